// File: doc/BRIEF.md
# Asynchronous Bus Slave Handshake Timer

This block is an I/O slave for an asynchronous backplane bus. It claims a window of sixteen consecutive locations in a 4096-location I/O space. The master holds its data strobe (active low) until the slave acknowledges, so the slave alone sets how long each transfer lasts. Once an access is decoded, a one is clocked along an eight-stage delay chain. One configurable stage drives the acknowledge. Two earlier stages are combined into a local write strobe whose start and end are both fixed in clocks.

Address, strobe and direction are synchronised to the local clock by two flops before they are used. The acknowledge and read data are presented with separate output-enable signals, which are high only while this slave is addressed and strobed. A sixteen-entry register file sits on the local side so the handshake can be exercised end to end.

Top module: `bus_hs_slave`

## Requirements
- R1: An access is taken only when the upper eight bits of the 12-bit address equal the parameter `BASE_PAGE` (default 8'hA5). For any other page, no acknowledge enable, no read enable and no register write occur.
- R2: `bus_ack_n` goes low at exactly the (ACK_TAP+3)-th rising clock edge after the strobe goes low. Two edges are spent in the synchroniser and ACK_TAP+1 edges in the chain. With the default ACK_TAP=4 this is the 7th edge.
- R3: On a write (`bus_rnw`=0), `loc_wr_pulse` is high for exactly two clocks, after the 4th and 5th edges. It is low again before or at the edge where acknowledge asserts, and the addressed register takes `bus_wdata`.
- R4: On a read (`bus_rnw`=1), `loc_wr_pulse` stays low and no register changes.
- R5: On a read, `bus_rdata_oe` and `loc_rd_en` rise after the 3rd edge. `bus_rdata` then carries the register selected by address bits 3:0 and stays stable until release.
- R6: When the strobe returns high, `bus_ack_oe` and `bus_rdata_oe` fall after the 2nd edge, and `bus_ack_n` returns high after the 3rd edge.
- R7: `bus_rdata_oe` is high only while `bus_ack_oe` is high.
- R8: While `rst` is high, and just after it, the outputs are idle (`bus_ack_n`=1, enables 0, `loc_wr_pulse`=0) and all registers read 0.
- R9: `loc_sel` shows address bits 3:0. Indices 0 and 15 reach distinct registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | I/O address from the master |
| bus_strb_n | input | 1 | Data strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Write data from the master |
| bus_rdata | output | 8 | Read data to the master |
| bus_rdata_oe | output | 1 | Drive enable for read data |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| bus_ack_oe | output | 1 | Drive enable for acknowledge |
| loc_sel | output | 4 | Local register select |
| loc_wr_pulse | output | 1 | Local write strobe |
| loc_rd_en | output | 1 | Local read enable |

## Verification
The assertions assume the master follows the handshake. The address, direction and write data are held steady for the whole time the strobe is low. The strobe is released only after acknowledge has been seen, and each access is followed by an idle gap long enough for the chain to clear. The bench drives every input on the falling clock edge and changes address and data only while the strobe is high. It waits for the release timing to finish before it starts the next access, so the stable-data and pulse-length properties hold throughout.

// File: rtl/bus_hs_pkg.sv
package bus_hs_pkg;
    localparam int IO_ADDR_W = 12;
    localparam int SEL_W     = 4;
    localparam int PAGE_W    = IO_ADDR_W - SEL_W;
    localparam int REGS      = 1 << SEL_W;
    localparam int SYNC_W    = IO_ADDR_W + 2;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [SEL_W-1:0]  sel;
        logic              strb_n;
        logic              rnw;
    } bus_req_t;

    typedef enum logic [1:0] {
        XFER_IDLE  = 2'b00,
        XFER_READ  = 2'b01,
        XFER_WRITE = 2'b10
    } xfer_kind_t;

    function automatic xfer_kind_t classify(input bus_req_t r,
                                            input logic [PAGE_W-1:0] base);
        if (r.strb_n || (r.page != base)) return XFER_IDLE;
        return r.rnw ? XFER_READ : XFER_WRITE;
    endfunction
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= rst_val;
            dout <= rst_val;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/hs_delay_chain.sv
module hs_delay_chain #(
    parameter int LEN    = 8,
    parameter int TAP    = 4,
    parameter int WR_ON  = 1,
    parameter int WR_OFF = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    output logic [LEN-1:0] stage,
    output logic           ack_tap,
    output logic           wr_window
);
    for (genvar i = 0; i < LEN; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst || !run) stage[i] <= 1'b0;
            else if (i == 0) stage[i] <= 1'b1;
            else             stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
    end

    assign ack_tap   = stage[TAP];
    assign wr_window = stage[WR_ON] & ~stage[WR_OFF];
endmodule

// File: rtl/hs_regfile.sv
module hs_regfile #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << SEL_W;
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                           mem[i] <= '0;
            else if (we && idx == SEL_W'(i))   mem[i] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/bus_hs_slave.sv
module bus_hs_slave
    import bus_hs_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter int               CHAIN_LEN = 8,
    parameter int               ACK_TAP   = 4,
    parameter logic [PAGE_W-1:0] BASE_PAGE = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_ADDR_W-1:0] bus_addr,
    input  logic                 bus_strb_n,
    input  logic                 bus_rnw,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rdata_oe,
    output logic                 bus_ack_n,
    output logic                 bus_ack_oe,
    output logic [SEL_W-1:0]     loc_sel,
    output logic                 loc_wr_pulse,
    output logic                 loc_rd_en
);
    localparam int WR_ON  = 1;
    localparam int WR_OFF = 3;

    if (ACK_TAP < WR_OFF || ACK_TAP >= CHAIN_LEN) begin : g_bad_tap
        initial $error("ACK_TAP must lie between the write-pulse end stage and the chain end");
    end

    bus_req_t   req_raw, req_s, req_idle;
    xfer_kind_t kind;
    logic       active, is_read;
    logic [CHAIN_LEN-1:0] stage;
    logic       ack_tap, wr_window;

    assign req_raw  = '{page: bus_addr[IO_ADDR_W-1:SEL_W], sel: bus_addr[SEL_W-1:0],
                        strb_n: bus_strb_n, rnw: bus_rnw};
    assign req_idle = '{page: '0, sel: '0, strb_n: 1'b1, rnw: 1'b1};

    hs_sync2 #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst(rst), .din(req_raw), .rst_val(req_idle), .dout(req_s)
    );

    assign kind    = classify(req_s, BASE_PAGE);
    assign active  = (kind != XFER_IDLE);
    assign is_read = (kind == XFER_READ);

    hs_delay_chain #(.LEN(CHAIN_LEN), .TAP(ACK_TAP), .WR_ON(WR_ON), .WR_OFF(WR_OFF)) u_chain (
        .clk(clk), .rst(rst), .run(active),
        .stage(stage), .ack_tap(ack_tap), .wr_window(wr_window)
    );

    assign loc_wr_pulse = wr_window & (kind == XFER_WRITE);
    assign loc_rd_en    = stage[0] & is_read;
    assign loc_sel      = req_s.sel;

    hs_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .we(loc_wr_pulse), .idx(req_s.sel),
        .wdata(bus_wdata), .rdata(bus_rdata)
    );

    assign bus_ack_n    = ~ack_tap;
    assign bus_ack_oe   = active;
    assign bus_rdata_oe = loc_rd_en;
endmodule

// File: rtl/bus_hs_slave_chk.sv
module bus_hs_slave_chk (
    input logic clk,
    input logic rst,
    input logic bus_ack_n,
    input logic bus_ack_oe,
    input logic bus_rdata_oe,
    input logic [7:0] bus_rdata,
    input logic loc_wr_pulse,
    input logic loc_rd_en
);
    p_wr_before_ack_r3: assert property (@(posedge clk) disable iff (rst)
        loc_wr_pulse |-> bus_ack_n);
    p_wr_min_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_wr_pulse) |=> loc_wr_pulse);
    p_wr_max_len_r3: assert property (@(posedge clk) disable iff (rst)
        (loc_wr_pulse && $past(loc_wr_pulse)) |=> !loc_wr_pulse);
    p_no_wr_on_rd_r4: assert property (@(posedge clk) disable iff (rst)
        loc_rd_en |-> !loc_wr_pulse);
    p_rdata_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata_oe && $past(bus_rdata_oe)) |-> $stable(bus_rdata));
    p_rdoe_in_sel_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> bus_ack_oe);
    p_ack_in_sel_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack_n) |-> bus_ack_oe);
    p_reset_idle_r8: assert property (@(posedge clk)
        rst |=> (bus_ack_n && !bus_ack_oe && !loc_wr_pulse));
endmodule

bind bus_hs_slave bus_hs_slave_chk u_chk (
    .clk(clk), .rst(rst), .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe),
    .bus_rdata_oe(bus_rdata_oe), .bus_rdata(bus_rdata),
    .loc_wr_pulse(loc_wr_pulse), .loc_rd_en(loc_rd_en)
);

// File: tb/bus_hs_slave_bench.sv
module bus_hs_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TAP = 4;
    localparam logic [7:0] PAGE = 8'hA5;

    logic clk = 0, rst = 1;
    logic [11:0] bus_addr = '0;
    logic bus_strb_n = 1, bus_rnw = 1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_rdata_oe, bus_ack_n, bus_ack_oe, loc_wr_pulse, loc_rd_en;
    logic [3:0] loc_sel;

    int checks = 0, failures = 0;
    logic [7:0] model [16];
    logic [7:0] expq [$];
    logic done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hs_slave #(.ACK_TAP(TAP), .BASE_PAGE(PAGE)) u_bus_hs_slave (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_strb_n(bus_strb_n),
        .bus_rnw(bus_rnw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe),
        .loc_sel(loc_sel), .loc_wr_pulse(loc_wr_pulse), .loc_rd_en(loc_rd_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop an expected read value at each acknowledge of a read
    initial begin
        logic prev_ack_n = 1;
        forever begin
            @(negedge clk);
            if (!rst && bus_ack_oe && !bus_ack_n && prev_ack_n && bus_rdata_oe) begin
                if (expq.size() == 0) check("R5 unexpected read", 1, 0);
                else check("R5 read data", int'(bus_rdata), int'(expq.pop_front()));
            end
            prev_ack_n = bus_ack_n;
        end
    end

    task automatic access(input logic [11:0] addr, input logic rnw, input logic [7:0] wd);
        bit hit = (addr[11:4] == PAGE);
        int ack_j = 0, wr_first = 0, wr_cnt = 0, rd_first = 0, oe_seen = 0;
        int sel_at_ack = -1;
        logic [7:0] rd_first_val = '0;
        int rd_changed = 0;
        if (hit && rnw) expq.push_back(model[addr[3:0]]);
        @(negedge clk);
        bus_addr = addr; bus_rnw = rnw; bus_wdata = wd; bus_strb_n = 0;
        for (int j = 1; j <= 14; j++) begin
            @(posedge clk); @(negedge clk);
            if (bus_ack_oe) oe_seen = 1;
            if (!bus_ack_n && ack_j == 0) begin ack_j = j; sel_at_ack = int'(loc_sel); end
            if (loc_wr_pulse) begin wr_cnt++; if (wr_first == 0) wr_first = j; end
            if (bus_rdata_oe) begin
                if (rd_first == 0) begin rd_first = j; rd_first_val = bus_rdata; end
                else if (bus_rdata != rd_first_val) rd_changed = 1;
            end
        end
        if (!hit) begin
            check("R1 no ack off page", ack_j, 0);
            check("R1 no ack_oe off page", oe_seen, 0);
            check("R1 no write off page", wr_cnt, 0);
            check("R1 no read off page", rd_first, 0);
        end else begin
            check("R2 ack edge", ack_j, TAP + 3);
            check("R9 loc_sel", sel_at_ack, int'(addr[3:0]));
            if (rnw) begin
                check("R4 no write on read", wr_cnt, 0);
                check("R5 rd enable edge", rd_first, 3);
                check("R5 rd data stable", rd_changed, 0);
            end else begin
                check("R3 write len", wr_cnt, 2);
                check("R3 write start", wr_first, 4);
                check("R3 write ends by ack", int'(wr_first + wr_cnt <= ack_j), 1);
                model[addr[3:0]] = wd;
            end
        end
        bus_strb_n = 1;
        @(posedge clk); @(negedge clk);
        if (hit) check("R6 ack_oe held 1 edge", int'(bus_ack_oe), 1);
        @(posedge clk); @(negedge clk);
        check("R6 ack_oe off", int'(bus_ack_oe), 0);
        check("R7 rdata_oe off", int'(bus_rdata_oe), 0);
        @(posedge clk); @(negedge clk);
        check("R6 ack_n high", int'(bus_ack_n), 1);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R8 ack_n in reset", int'(bus_ack_n), 1);
        check("R8 ack_oe in reset", int'(bus_ack_oe), 0);
        check("R8 wr in reset", int'(loc_wr_pulse), 0);
        rst = 0;
        access({PAGE, 4'd3}, 1, 8'h00);          // R8 register cleared
        access({PAGE, 4'd0}, 0, 8'h5A);          // R3
        access({PAGE, 4'd15}, 0, 8'hC3);         // R9 upper boundary
        access({PAGE, 4'd0}, 1, 8'h00);          // R5, R9
        access({PAGE, 4'd15}, 1, 8'hFF);         // R4 read with data bus busy
        access({8'hA4, 4'd0}, 0, 8'h11);         // R1 page below
        access({8'hA6, 4'd15}, 1, 8'h00);        // R1 page above
        access({PAGE, 4'd0}, 1, 8'h00);          // R1 register untouched
        access({PAGE, 4'd7}, 0, 8'h81);
        access({PAGE, 4'd7}, 1, 8'h00);
        access({PAGE, 4'd15}, 1, 8'h00);
        repeat (4) @(negedge clk);
        check("R5 scoreboard drained", expq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule